// File: doc/BRIEF.md
# Interrupt Controller Register File

This block keeps the enable, pending and priority state for 32 external interrupt lines and makes it reachable through a 32-bit memory-mapped register port. A rising edge on any request input latches that line as pending, whether or not the line is enabled. Software can set or clear enable and pending bits through separate alias registers. In each alias, a 1 bit acts on its line and a 0 bit is ignored.

Each line has a priority field. Priority fields are packed four to a word, one per byte. Only the upper `PRIO_BITS` bits of each byte are stored. The block continuously reports which line is enabled and pending with the most urgent priority, and raises a request flag toward the core while such a line exists. The core acknowledges a line by pulsing an acknowledge input together with the line number, and that clears the line's pending bit.

Top module: `irq_regfile`

## Requirements
- R1: After reset, all enable bits, pending bits and priority fields are zero, and `irq_req` is low.
- R2: A write to offset 0x000 sets the enable bit of every line whose data bit is 1; data bits that are 0 change nothing. Reads of 0x000 and of 0x080 both return the 32 enable bits, with line n at bit n.
- R3: A write to offset 0x080 clears the enable bit of every line whose data bit is 1; data bits that are 0 change nothing.
- R4: A write to 0x100 sets pending bits and a write to 0x180 clears pending bits, each acting only on 1 bits. Reads of either offset return the 32 pending bits, with line n at bit n.
- R5: A 0-to-1 change on `irq_in[n]`, seen between two consecutive clock edges, sets pending bit n even when line n is disabled. A request input held high does not set the bit again after it has been cleared.
- R6: Priority word k (k = 0..7) is at offset 0x300 + 4k. Line n lives in word n>>2, in byte bits [(n&3)*8+7 : (n&3)*8]. Only the top `PRIO_BITS` bits of each byte are stored, and the lower bits of each byte read as zero.
- R7: While `irq_req` is high, `irq_line` is the line that is both enabled and pending and has the numerically lowest priority value. When several such lines share that value, the lowest line number wins.
- R8: `irq_req` is low whenever no line is both enabled and pending.
- R9: When `ack` is high at a clock edge, the pending bit of line `ack_line` is clear after that edge.
- R10: If a set of a pending bit (a request edge or a write to 0x100) and a clear of the same bit (a write to 0x180 or an acknowledge) happen at the same clock edge, the bit ends up set.
- R11: An address that is not one of the mapped words, or that has nonzero bits [1:0], reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, edge detected |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ack | input | 1 | Acknowledge pulse from the core |
| ack_line | input | 5 | Line number being acknowledged |
| irq_req | output | 1 | A line is enabled and pending |
| irq_line | output | 5 | Number of the selected line |

## Verification
The hardest cases to create from the ports are coincidences on a single bit: a request edge, or a set-pending write, arriving at the same edge as a clear-pending write or an acknowledge of that same line. Reaching them requires cycle-exact alignment of `irq_in` with the bus write or the `ack` pulse. The stimulus builds these by driving both in the same cycle after a negative edge. Priority ties between lines in different words are set up by writing bytes whose truncated values are equal, which exercises the lowest-number tie-break. A behavioural model compares the outputs on every clock.

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int PRIO_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_in,
  input  logic        wr_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ack,
  input  logic [4:0]  ack_line,
  output logic        irq_req,
  output logic [4:0]  irq_line
);
  localparam int NL = 32;
  localparam int SH = 8 - PRIO_BITS;

  logic [31:0] en_q, pend_q, irq_q;
  logic [PRIO_BITS-1:0] prio_q [NL];

  wire       aligned  = addr[1:0] == 2'b00;
  wire [9:0] wa       = addr[11:2];
  wire hit_sen  = aligned && wa == 10'h000;
  wire hit_cen  = aligned && wa == 10'h020;
  wire hit_spd  = aligned && wa == 10'h040;
  wire hit_cpd  = aligned && wa == 10'h060;
  wire hit_prio = aligned && wa[9:3] == 7'h18;
  wire [2:0] widx = wa[2:0];

  wire [31:0] edge_w     = irq_in & ~irq_q;
  wire [31:0] set_pend_w = (wr_en && hit_spd) ? wdata : 32'h0;
  wire [31:0] clr_pend_w = (wr_en && hit_cpd) ? wdata : 32'h0;
  wire [31:0] ack_mask   = ack ? (32'h1 << ack_line) : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= (pend_q & ~clr_pend_w & ~ack_mask) | set_pend_w | edge_w;
      if (wr_en && hit_sen) en_q <= en_q | wdata;
      else if (wr_en && hit_cen) en_q <= en_q & ~wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          prio_q[g] <= '0;
        else if (wr_en && hit_prio && widx == 3'(g / 4))
          prio_q[g] <= wdata[(g % 4) * 8 + 7 -: PRIO_BITS];
      end
    end
  endgenerate

  logic [31:0] prio_word;
  always_comb begin
    for (int j = 0; j < 4; j++)
      prio_word[j*8 +: 8] = 8'(prio_q[{widx, 2'(j)}]) << SH;
  end

  always_comb begin
    rdata = 32'h0;
    if (hit_sen || hit_cen)      rdata = en_q;
    else if (hit_spd || hit_cpd) rdata = pend_q;
    else if (hit_prio)           rdata = prio_word;
  end

  logic [31:0]          live;
  logic                 found;
  logic [PRIO_BITS-1:0] best_p;
  logic [4:0]           best_n;
  assign live = en_q & pend_q;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_n = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (live[i] && (!found || prio_q[i] <= best_p)) begin
        found  = 1'b1;
        best_p = prio_q[i];
        best_n = 5'(i);
      end
    end
  end

  assign irq_req  = found;
  assign irq_line = best_n;

  // R7
  sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q[irq_line] && pend_q[irq_line]));

  // R8
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 32'h0) |-> !irq_req);

  // R2
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_sen) |=> ((en_q & $past(wdata)) == $past(wdata)));

  // R3
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_cen) |=> ((en_q & $past(wdata)) == 32'h0));

  // R11
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (hit_sen || hit_cen)) |=> $stable(en_q));

  // R9
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_pend_w[ack_line] && !edge_w[ack_line]) |=> !pend_q[$past(ack_line)]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_pend_w | edge_w) != 32'h0) |=> ((pend_q & $past(set_pend_w | edge_w)) == $past(set_pend_w | edge_w)));

  // R6
  always_comb begin
    if (rst_n && hit_prio)
      low_bits_zero_chk: assert ((rdata & {4{~(8'hFF << SH)}}) == 32'h0);
  end
endmodule

// File: tb/irq_regfile_tb.sv
module irq_regfile_tb;
  localparam int PB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack = 1'b0;
  logic [4:0]  ack_line = '0;
  logic        irq_req;
  logic [4:0]  irq_line;

  always #4 clk = ~clk;

  irq_regfile #(.PRIO_BITS(PB)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack(ack), .ack_line(ack_line),
    .irq_req(irq_req), .irq_line(irq_line)
  );

  bit m_en[32], m_pd[32], m_prev[32];
  int m_pr[32];
  int total = 0, bad = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_en[i] = 0; m_pd[i] = 0; m_prev[i] = 0; m_pr[i] = 0;
      end
    end else begin
      int a;
      a = int'(addr);
      for (int i = 0; i < 32; i++) begin
        bit rise, sp, cp, ak;
        rise = irq_in[i] && !m_prev[i];
        sp = wr_en && a == 'h100 && wdata[i];
        cp = wr_en && a == 'h180 && wdata[i];
        ak = ack && int'(ack_line) == i;
        m_pd[i] = (m_pd[i] && !cp && !ak) || sp || rise;
        m_prev[i] = irq_in[i];
        if (wr_en && a == 'h000 && wdata[i]) m_en[i] = 1;
        if (wr_en && a == 'h080 && wdata[i]) m_en[i] = 0;
      end
      if (wr_en && a >= 'h300 && a <= 'h31C && a % 4 == 0)
        for (int j = 0; j < 4; j++)
          m_pr[(a - 'h300) + j] = int'((wdata >> (8*j + 8 - PB)) & ((1 << PB) - 1));
    end
  end

  function automatic logic [31:0] m_rd(int a);
    logic [31:0] v;
    v = '0;
    if (a == 'h000 || a == 'h080) begin
      for (int i = 0; i < 32; i++) v[i] = m_en[i];
    end else if (a == 'h100 || a == 'h180) begin
      for (int i = 0; i < 32; i++) v[i] = m_pd[i];
    end else if (a >= 'h300 && a <= 'h31C && a % 4 == 0) begin
      for (int j = 0; j < 4; j++)
        v = v | (32'(m_pr[(a - 'h300) + j] << (8 - PB)) << (8*j));
    end
    return v;
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic cyc();
    int best;
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      best = -1;
      for (int i = 0; i < 32; i++)
        if (m_en[i] && m_pd[i] && (best < 0 || m_pr[i] < m_pr[best])) best = i;
      check({tag, " req"}, 32'(irq_req), 32'(best >= 0));
      if (best >= 0) check({tag, " line"}, 32'(irq_line), 32'(best));
      check({tag, " rdata"}, rdata, m_rd(int'(addr)));
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; addr = 12'(a); wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(int a);
    addr = 12'(a);
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; rd('h000);
    check("R1 enables", rdata, 32'h0);
    check("R1 req", 32'(irq_req), 32'h0);
    rd('h100); check("R1 pending", rdata, 32'h0);
    rd('h300); check("R1 prio", rdata, 32'h0);

    tag = "R2"; wr('h000, 32'h0000_00F0); rd('h080);
    check("R2 read alias", rdata, 32'h0000_00F0);
    wr('h000, 32'h0); rd('h000);
    check("R2 zero no effect", rdata, 32'h0000_00F0);

    tag = "R3"; wr('h080, 32'h0000_0030); rd('h000);
    check("R3 cleared", rdata, 32'h0000_00C0);

    tag = "R4"; wr('h100, 32'h0000_0081); rd('h180);
    check("R4 pending", rdata, 32'h0000_0081);
    tag = "R7"; rd('h100);
    check("R7 line 7", 32'(irq_line), 32'd7);
    tag = "R8"; wr('h180, 32'h0000_0080); rd('h100);
    check("R8 no req", 32'(irq_req), 32'h0);

    tag = "R6"; wr('h304, 32'hFFFF_FFFF); rd('h304);
    check("R6 truncated", rdata, 32'hC0C0_C0C0);
    wr('h304, 32'h4080_C000); rd('h304);
    check("R6 lanes", rdata, 32'h4080_C000);
    wr('h308, 32'h0000_007F); rd('h308);
    check("R6 top bits", rdata, 32'h0000_0040);

    tag = "R7"; wr('h000, 32'hFFFF_FFFF);
    wr('h180, 32'hFFFF_FFFF);
    wr('h100, 32'h0000_00C0); rd('h100);
    check("R7 lowest value", 32'(irq_line), 32'd7);
    wr('h100, 32'h0000_0120); rd('h100);
    check("R7 tie to lower line", 32'(irq_line), 32'd7);

    tag = "R9"; ack = 1'b1; ack_line = 5'd7; cyc(); ack = 1'b0;
    rd('h100);
    check("R9 ack cleared", rdata & 32'h80, 32'h0);
    check("R9 next line", 32'(irq_line), 32'd8);

    tag = "R5"; wr('h080, 32'h0010_0000);
    irq_in[20] = 1'b1; rd('h100);
    check("R5 edge while disabled", rdata & 32'h0010_0000, 32'h0010_0000);
    wr('h180, 32'h0010_0000); rd('h100); rd('h100);
    check("R5 held level", rdata & 32'h0010_0000, 32'h0);
    irq_in[20] = 1'b0; cyc(); irq_in[20] = 1'b1; rd('h100);
    check("R5 new edge", rdata & 32'h0010_0000, 32'h0010_0000);

    tag = "R10"; irq_in[21] = 1'b1; wr('h180, 32'h0020_0000); rd('h100);
    check("R10 edge beats clear", rdata & 32'h0020_0000, 32'h0020_0000);
    ack = 1'b1; ack_line = 5'd3; wr('h100, 32'h0000_0008); ack = 1'b0;
    rd('h100);
    check("R10 set beats ack", rdata & 32'h8, 32'h8);

    tag = "R11"; rd('h000);
    wr('h040, 32'hFFFF_FFFF); rd('h040);
    check("R11 unmapped", rdata, 32'h0);
    wr('h002, 32'h0000_0001); rd('h080);
    check("R11 misaligned", rdata, 32'hFFEF_FFFF);
    rd('h320); check("R11 past prio", rdata, 32'h0);
    rd('h301); check("R11 misaligned read", rdata, 32'h0);

    irq_in = '0;
    repeat (3) cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule